// File: doc/BRIEF.md
# Repeating Scan Trigger Generator

This block decides when a sampling converter starts a scan. Its output is a single-cycle `scan_start` pulse. The pulse comes from one of several event sources chosen by software. These are four asynchronous external trigger pins, an on-chip comparator output and a software strobe. A free-running interval timer can also drive it. The timer runs on the converter clock through a power-of-two prescaler and a 10-bit terminal counter. On each wrap of the counter it produces an internal tick.

Two modes exist. In single-scan mode every selected event starts one scan. In repeating mode the first selected event starts one scan and arms the block. After that, scans follow a periodic tick, which is either the internal timer or an external timer tick input. This continues until the converter enable is cleared or the internal timer is switched off. Two 16-bit registers hold all settings and can be read back. Address 0 is the timer register and address 1 is the control register.

Top module: `scan_trig_gen`

## Requirements
- R1: After reset both registers read 0, and `scan_start` is low. While the timer enable (timer register bit 15) is 0, the internal timer produces no ticks and its counters are held at zero.
- R2: The prescaler field (timer register bits 12:10) holds n and divides the clock by 2^n. A written value above 5 is stored and read back as 5.
- R3: With the timer enabled, terminal count T (timer register bits 9:0, legal 1..1023) and prescaler n, consecutive internal ticks are exactly T·2^n clock cycles apart.
- R4: While the timer enable reads 1, writes to the timer register leave n and T unchanged. The enable bit itself still takes the written value.
- R5: The source field (control register bits 6:4) selects the event source. Codes 0..3 select external pins 0..3 and code 4 selects the comparator (rising edge only). Code 7 selects `sw_trig`. `scan_start` rises one cycle after a `sw_trig` strobe, and three cycles after an external or comparator edge (two synchronizer flops plus edge register).
- R6: Source codes 5 and 6 never produce a scan, whatever the inputs do.
- R7: The polarity bit (control register bit 3) picks the active edge of the external pins: 0 selects rising and 1 selects falling. The opposite edge and edges on unselected pins produce nothing.
- R8: In single-scan mode (control bit 1 = 0), each event produces exactly one `scan_start` pulse, one cycle wide.
- R9: While the converter enable (control bit 0) is 0, no scan is started, and any repeating-mode arming is dropped. A new event is then needed to re-arm.
- R10: In repeating mode (control bit 1 = 1), scans before the first event are suppressed. The first event gives one scan, and later scans follow the periodic tick only, with events ignored. Control bit 2 picks the tick source: 1 selects the internal timer and 0 selects `tmr_tick`. Clearing the timer enable while the internal tick is selected stops the scans and drops the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 timer, 1 control |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| ext_trig | input | 4 | Asynchronous external trigger pins |
| cmp_in | input | 1 | Comparator output |
| sw_trig | input | 1 | Software trigger strobe, synchronous |
| tmr_tick | input | 1 | Periodic tick from an outside timer, synchronous |
| scan_start | output | 1 | One-cycle scan start pulse |

## Verification
The bench uses the default build: a two-flop synchronizer, four external pins and a largest prescaler exponent of 5. This means every prescaler setting from divide-by-1 to divide-by-32 can be measured within a few hundred cycles. Terminal counts are kept between 1 and 24, so the bench can time several random (n, T) pairs and the extremes T=1/n=0 and n=5. With a fixed seed it also covers every external pin in both polarities. The fixed latency from each source makes the exact cycle of each edge-triggered scan predictable.

// File: rtl/scan_trig_pkg.sv
package scan_trig_pkg;

    localparam int TMAX_W  = 10;
    localparam int DIV_W   = 3;
    localparam int DIV_MAX = 5;
    localparam int NUM_EXT = 4;
    localparam int REG_W   = 16;

    // timer register layout
    localparam int TEN_BIT = 15;
    localparam int DIV_LSB = 10;

    // control register layout
    localparam int CONV_BIT = 0;
    localparam int RPT_BIT  = 1;
    localparam int PINT_BIT = 2;
    localparam int FALL_BIT = 3;
    localparam int SRC_LSB  = 4;

    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_EXT1 = 3'd1,
        SRC_EXT2 = 3'd2,
        SRC_EXT3 = 3'd3,
        SRC_CMP  = 3'd4,
        SRC_RSV5 = 3'd5,
        SRC_RSV6 = 3'd6,
        SRC_SW   = 3'd7
    } src_e;

    typedef struct packed {
        logic              en;
        logic [DIV_W-1:0]  div;
        logic [TMAX_W-1:0] tmax;
    } tmr_cfg_t;

    typedef struct packed {
        src_e src;
        logic fall;
        logic per_int;
        logic rpt;
        logic conv_en;
    } ctl_cfg_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (int'(d) > DIV_MAX) ? DIV_W'(DIV_MAX) : d;
    endfunction

    function automatic logic [DIV_MAX-1:0] pre_mask(input logic [DIV_W-1:0] d);
        return DIV_MAX'((32'd1 << d) - 32'd1);
    endfunction

endpackage

// File: rtl/stg_cfg_regs.sv
module stg_cfg_regs
    import scan_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output tmr_cfg_t         tcfg,
    output ctl_cfg_t         ccfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcfg <= '0;
            ccfg <= '0;
        end else if (we) begin
            if (!addr) begin
                tcfg.en <= wdata[TEN_BIT];
                if (!tcfg.en) begin
                    tcfg.div  <= clamp_div(wdata[DIV_LSB +: DIV_W]);
                    tcfg.tmax <= wdata[TMAX_W-1:0];
                end
            end else begin
                ccfg.conv_en <= wdata[CONV_BIT];
                ccfg.rpt     <= wdata[RPT_BIT];
                ccfg.per_int <= wdata[PINT_BIT];
                ccfg.fall    <= wdata[FALL_BIT];
                ccfg.src     <= src_e'(wdata[SRC_LSB +: 3]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[TEN_BIT]             = tcfg.en;
            rdata[DIV_LSB +: DIV_W]    = tcfg.div;
            rdata[TMAX_W-1:0]          = tcfg.tmax;
        end else begin
            rdata[CONV_BIT]            = ccfg.conv_en;
            rdata[RPT_BIT]             = ccfg.rpt;
            rdata[PINT_BIT]            = ccfg.per_int;
            rdata[FALL_BIT]            = ccfg.fall;
            rdata[SRC_LSB +: 3]        = ccfg.src;
        end
    end

    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        int'(tcfg.div) <= DIV_MAX); // R2
    AST_TIMER_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (tcfg.en && $past(tcfg.en)) |-> ($stable(tcfg.div) && $stable(tcfg.tmax))); // R4

endmodule

// File: rtl/stg_timer.sv
module stg_timer
    import scan_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic [TMAX_W-1:0] tmax,
    output logic              tick
);

    logic [DIV_MAX-1:0] pcnt;
    logic [TMAX_W-1:0]  cnt;
    logic               ce;

    assign ce = en && ((pcnt & pre_mask(div)) == pre_mask(div));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt <= '0;
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            pcnt <= pcnt + 1'b1;
            tick <= 1'b0;
            if (ce) begin
                if (cnt == TMAX_W'(tmax - 1'b1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick); // R1
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en && tmax != '0) |-> (cnt < tmax)); // R3

endmodule

// File: rtl/stg_sync_edge.sv
module stg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fall,
    output logic pulse
);

    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign pulse = fall ? (sh[STAGES] & ~sh[STAGES-1])
                        : (sh[STAGES-1] & ~sh[STAGES]);

endmodule

// File: rtl/scan_trig_gen.sv
module scan_trig_gen
    import scan_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic [NUM_EXT-1:0] ext_trig,
    input  logic               cmp_in,
    input  logic               sw_trig,
    input  logic               tmr_tick,
    output logic               scan_start
);

    tmr_cfg_t         tcfg;
    ctl_cfg_t         ccfg;
    logic             itick;
    logic [NUM_EXT:0] pins;
    logic [NUM_EXT:0] ev;
    logic             trig_evt;
    logic             per_tick;
    logic             armed;

    stg_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .tcfg  (tcfg),
        .ccfg  (ccfg)
    );

    stg_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (tcfg.en),
        .div  (tcfg.div),
        .tmax (tcfg.tmax),
        .tick (itick)
    );

    assign pins = {cmp_in, ext_trig};

    for (genvar gi = 0; gi <= NUM_EXT; gi++) begin : g_in
        logic use_fall;
        if (gi < NUM_EXT) begin : g_ext
            assign use_fall = ccfg.fall;
        end else begin : g_cmp
            assign use_fall = 1'b0;
        end
        stg_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
            .clk   (clk),
            .rst   (rst),
            .din   (pins[gi]),
            .fall  (use_fall),
            .pulse (ev[gi])
        );
    end

    always_comb begin
        unique case (ccfg.src)
            SRC_EXT0, SRC_EXT1,
            SRC_EXT2, SRC_EXT3: trig_evt = ev[{1'b0, ccfg.src[1:0]}];
            SRC_CMP:            trig_evt = ev[NUM_EXT];
            SRC_SW:             trig_evt = sw_trig;
            default:            trig_evt = 1'b0;
        endcase
    end

    assign per_tick = ccfg.per_int ? itick : tmr_tick;

    always_ff @(posedge clk) begin
        if (rst || !ccfg.conv_en || !ccfg.rpt || (ccfg.per_int && !tcfg.en))
            armed <= 1'b0;
        else if (trig_evt)
            armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) scan_start <= 1'b0;
        else     scan_start <= ccfg.conv_en && (armed ? per_tick : trig_evt);
    end

    AST_CONV_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ccfg.conv_en |=> !scan_start); // R9
    AST_RSV_SRC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!armed && (ccfg.src == SRC_RSV5 || ccfg.src == SRC_RSV6)) |=> !scan_start); // R6
    AST_SW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ccfg.conv_en && !ccfg.rpt && ccfg.src == SRC_SW && sw_trig) |=> scan_start); // R8
    AST_ARMED_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
        (armed && ccfg.conv_en && !per_tick) |=> !scan_start); // R10

endmodule

// File: tb/scan_trig_gen_tb.sv
module scan_trig_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  ext_trig = '0;
    logic        cmp_in = 1'b0;
    logic        sw_trig = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        scan_start;

    int vec = 0;
    int bad = 0;
    int cyc = 0;
    int npulse = 0;
    int t_last = 0;
    int t_prev = 0;

    always #2.5 clk = ~clk;

    scan_trig_gen u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_trig(ext_trig),
        .cmp_in(cmp_in), .sw_trig(sw_trig), .tmr_tick(tmr_tick),
        .scan_start(scan_start)
    );

    always @(negedge clk) begin
        cyc++;
        if (scan_start) begin
            npulse++;
            t_prev = t_last;
            t_last = cyc;
        end
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    function automatic logic [15:0] tmr_word(input bit en, input int n, input int t);
        return {en, 2'b00, 3'(n), 10'(t)};
    endfunction

    function automatic logic [15:0] ctl_word(input int src, input bit fall, input bit pint,
                                             input bit rpt, input bit conv);
        return {9'd0, 3'(src), fall, pint, rpt, conv};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_sw();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic strobe_tmr();
        @(negedge clk); tmr_tick = 1'b1;
        @(negedge clk); tmr_tick = 1'b0;
    endtask

    task automatic wait_pulses(input int target);
        int lim = 0;
        while (npulse < target && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    initial begin
        logic [15:0] rv;
        int p0;
        void'($urandom(32'h5CA1));

        idle(5);
        // R1: reset state
        chk("R1 scan_start at reset", int'(scan_start), 0);
        rst = 1'b0;
        idle(2);
        rd(1'b0, rv); chk("R1 timer reg reset", int'(rv), 0);
        rd(1'b1, rv); chk("R1 control reg reset", int'(rv), 0);
        p0 = npulse; idle(50);
        chk("R1 no scans after reset", npulse - p0, 0);

        // R5 / R8: software trigger, single mode
        wr(1'b1, ctl_word(7, 0, 0, 0, 1));
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
        chk("R5 sw latency one cycle", int'(scan_start), 1);
        @(negedge clk);
        chk("R8 pulse one cycle wide", int'(scan_start), 0);
        p0 = npulse;
        for (int i = 0; i < 3; i++) begin strobe_sw(); idle(2); end
        idle(3);
        chk("R8 one scan per event", npulse - p0, 3);

        // R9: converter disabled
        wr(1'b1, ctl_word(7, 0, 0, 0, 0));
        p0 = npulse;
        strobe_sw(); idle(5);
        chk("R9 no scan with converter off", npulse - p0, 0);

        // R6: unused codes 5 and 6
        for (int c = 5; c <= 6; c++) begin
            wr(1'b1, ctl_word(c, 0, 0, 0, 1));
            p0 = npulse;
            strobe_sw();
            @(negedge clk); ext_trig = 4'hF; cmp_in = 1'b1;
            idle(6);
            @(negedge clk); ext_trig = 4'h0; cmp_in = 1'b0;
            idle(6);
            chk("R6 unused source silent", npulse - p0, 0);
        end

        // R5 / R7: external pins, random index and polarity
        for (int it = 0; it < 8; it++) begin
            int idx = int'($urandom % 4);
            bit pol = bit'($urandom % 2);
            int oth = (idx + 1 + int'($urandom % 3)) % 4;
            wr(1'b1, ctl_word(idx, pol, 0, 0, 1));
            @(negedge clk); ext_trig = pol ? 4'hF : 4'h0;
            idle(6);
            p0 = npulse;
            @(negedge clk); ext_trig[idx] = ~pol;
            idle(3);
            chk("R5 ext latency three cycles", int'(scan_start), 1);
            idle(3);
            @(negedge clk); ext_trig[idx] = pol;
            idle(5);
            @(negedge clk); ext_trig[oth] = ~pol;
            idle(5);
            @(negedge clk); ext_trig[oth] = pol;
            idle(6);
            chk("R7 only selected pin and edge", npulse - p0, 1);
        end
        @(negedge clk); ext_trig = 4'h0;
        idle(6);

        // R5: comparator rising edge only
        wr(1'b1, ctl_word(4, 1, 0, 0, 1));
        p0 = npulse;
        @(negedge clk); cmp_in = 1'b1;
        idle(3);
        chk("R5 comparator latency", int'(scan_start), 1);
        idle(4);
        @(negedge clk); cmp_in = 1'b0;
        idle(6);
        chk("R5 comparator rising only", npulse - p0, 1);

        // R2: prescaler clamp
        wr(1'b0, tmr_word(0, 7, 5));
        rd(1'b0, rv);
        chk("R2 prescaler clamp", int'(rv[12:10]), 5);
        chk("R2 terminal count stored", int'(rv[9:0]), 5);

        // R3 / R10: period in repeating mode, directed and random settings
        for (int it = 0; it < 8; it++) begin
            int n = (it == 0) ? 0 : (it == 1) ? 5 : int'($urandom % 6);
            int t = (it == 0) ? 1 : (it == 1) ? 3 : 1 + int'($urandom % 24);
            int per = t << n;
            wr(1'b0, tmr_word(0, n, t));
            wr(1'b1, ctl_word(7, 0, 1, 1, 1));
            wr(1'b0, tmr_word(1, n, t));
            p0 = npulse;
            idle(2 * per + 4);
            chk("R10 no scan before first event", npulse - p0, 0);
            strobe_sw();
            wait_pulses(p0 + 3);
            chk("R3 tick period", t_last - t_prev, per);
            wr(1'b0, tmr_word(0, n, t));
            idle(4);
        end

        // R4: locked fields while enabled, then R10 stop and re-arm
        wr(1'b0, tmr_word(0, 2, 7));
        wr(1'b1, ctl_word(7, 0, 1, 1, 1));
        wr(1'b0, tmr_word(1, 2, 7));
        wr(1'b0, tmr_word(1, 4, 19));
        rd(1'b0, rv);
        chk("R4 tmax unchanged while enabled", int'(rv[9:0]), 7);
        chk("R4 prescaler unchanged while enabled", int'(rv[12:10]), 2);
        p0 = npulse;
        strobe_sw();
        wait_pulses(p0 + 3);
        chk("R4 period unchanged", t_last - t_prev, 28);
        wr(1'b0, tmr_word(0, 1, 3));
        rd(1'b0, rv);
        chk("R4 enable still writable", int'(rv[15]), 0);
        chk("R4 disabling write keeps tmax", int'(rv[9:0]), 7);
        idle(3);
        p0 = npulse;
        idle(90);
        chk("R10 scans stop when timer off", npulse - p0, 0);
        wr(1'b0, tmr_word(1, 2, 7));
        p0 = npulse;
        idle(90);
        chk("R10 re-arm needed after stop", npulse - p0, 0);
        wr(1'b0, tmr_word(0, 2, 7));
        idle(3);

        // R10 / R9: external tick source
        wr(1'b1, ctl_word(7, 0, 0, 1, 1));
        p0 = npulse;
        for (int i = 0; i < 3; i++) begin strobe_tmr(); idle(2); end
        chk("R10 ext tick ignored before arm", npulse - p0, 0);
        strobe_sw(); idle(2);
        chk("R10 arming event scans once", npulse - p0, 1);
        p0 = npulse;
        for (int i = 0; i < 4; i++) begin strobe_tmr(); idle(1); strobe_sw(); idle(1); end
        idle(2);
        chk("R10 armed follows tick only", npulse - p0, 4);
        wr(1'b1, ctl_word(7, 0, 0, 1, 0));
        wr(1'b1, ctl_word(7, 0, 0, 1, 1));
        p0 = npulse;
        for (int i = 0; i < 3; i++) begin strobe_tmr(); idle(2); end
        chk("R9 converter off drops arming", npulse - p0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule